// File: doc/BRIEF.md
# Six-State Shuffled Sequence Counter

This block is a three-bit synchronous counter. It does not count in binary. It walks a fixed loop of six values, one step on each rising clock edge: 6, 5, 2, 4, 1, 0, and then back to 6. Each state bit sits in a JK-style storage element. Every J and K input comes from combinational excitation logic that decodes the present state. All three elements share one clock, and there is no ripple clocking.

The two codes outside the loop are 3 and 7. When the counter finds itself in either of them, it moves to 6 on the next enabled edge. An active-low asynchronous clear puts the counter at 6 at once. A low enable forces every J and K input to 0, so the state holds. A decoder drives an active-low seven-segment pattern that shows the present value as a decimal digit.

Top module: `seq6_jk_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 6 without waiting for a clock edge. This is also the value after reset is released.
- R2: While `en` is high, each rising edge of `clk` moves `count` one step along the loop 6→5→2→4→1→0→6.
- R3: While `en` is low, `count` keeps its value across any number of rising edges. This includes the unused codes 3 and 7.
- R4: From code 3 or code 7, the next enabled rising edge sets `count` to 6.
- R5: After an enabled rising edge from any state whose bit 0 is 1, bit 0 is 0. The K input of bit 0 is permanently high whenever the counter is enabled.
- R6: `count` changes only on the rising edge of `clk` or on a falling edge of `rst_n`. It stays steady through the falling clock edge and for the rest of the cycle.
- R7: `seg_n` is active-low with bit order {g,f,e,d,c,b,a}, bit 0 being segment a. It follows `count` in the same cycle with these codes: 0→7'h40, 1→7'h79, 2→7'h24, 3→7'h30, 4→7'h19, 5→7'h12, 6→7'h02, 7→7'h78.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst_n | input | 1 | Asynchronous clear, active low; forces the state to 6 |
| en | input | 1 | Count enable; when low, all J/K inputs are 0 |
| count | output | 3 | Present state value |
| seg_n | output | 7 | Active-low seven-segment pattern {g,f,e,d,c,b,a} |

## Verification
A wrong J/K pair for any single state shows at the ports one edge after that state is entered. The counter then lands on a wrong successor, and every later value in the loop is shifted from the expected order. A wrong recovery entry shows only after the state has been forced to 3 or 7. For that reason the bench drives the counter into both unused codes, with enable low and with enable high, and compares the next value with 6. A decoder fault appears on `seg_n` in the same cycle as the digit it affects, so each loop value is checked on both outputs.

// File: rtl/seq6_pkg.sv
package seq6_pkg;
    localparam int CNT_W = 3;
    localparam int SEG_W = 7;

    typedef enum logic [CNT_W-1:0] {
        ST_D0 = 3'd0,
        ST_D1 = 3'd1,
        ST_D2 = 3'd2,
        ST_D3 = 3'd3,
        ST_D4 = 3'd4,
        ST_D5 = 3'd5,
        ST_D6 = 3'd6,
        ST_D7 = 3'd7
    } cnt_state_e;

    // Loop entry value, used by clear and by recovery.
    localparam cnt_state_e ST_START = ST_D6;
endpackage

// File: rtl/seq6_jk_bank.sv
module seq6_jk_bank #(
    parameter int              W    = 3,
    parameter logic [W-1:0]    INIT = '0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] j,
    input  logic [W-1:0] k,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Every bit behaves as a JK element: 00 hold, 10 set, 01 clear, 11 toggle.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q_r <= INIT;
        end else begin
            for (int b = 0; b < W; b++) begin
                unique case ({j[b], k[b]})
                    2'b00: q_r[b] <= q_r[b];
                    2'b10: q_r[b] <= 1'b1;
                    2'b01: q_r[b] <= 1'b0;
                    2'b11: q_r[b] <= ~q_r[b];
                    default: q_r[b] <= q_r[b];
                endcase
            end
        end
    end

    assign q = q_r;
endmodule

// File: rtl/seq6_excite.sv
module seq6_excite
    import seq6_pkg::*;
(
    input  cnt_state_e       cur,
    input  logic             en,
    output logic [CNT_W-1:0] j,
    output logic [CNT_W-1:0] k
);
    logic [CNT_W-1:0] j_raw;
    logic [CNT_W-1:0] k_raw;

    // Bit order of j/k is {bit2, bit1, bit0}; K of bit0 is high in every state.
    always_comb begin
        unique case (cur)
            ST_D6: begin j_raw = 3'b101; k_raw = 3'b011; end // 6 -> 5
            ST_D5: begin j_raw = 3'b011; k_raw = 3'b101; end // 5 -> 2
            ST_D2: begin j_raw = 3'b110; k_raw = 3'b011; end // 2 -> 4
            ST_D4: begin j_raw = 3'b101; k_raw = 3'b111; end // 4 -> 1
            ST_D1: begin j_raw = 3'b000; k_raw = 3'b101; end // 1 -> 0
            ST_D0: begin j_raw = 3'b110; k_raw = 3'b111; end // 0 -> 6
            ST_D3: begin j_raw = 3'b100; k_raw = 3'b001; end // 3 -> 6 recovery
            ST_D7: begin j_raw = 3'b111; k_raw = 3'b001; end // 7 -> 6 recovery
            default: begin j_raw = '0; k_raw = '0; end
        endcase
    end

    // Disabled: all inputs low, so every element holds.
    assign j = en ? j_raw : '0;
    assign k = en ? k_raw : '0;
endmodule

// File: rtl/seq6_seg_decode.sv
module seq6_seg_decode
    import seq6_pkg::*;
(
    input  cnt_state_e       val,
    output logic [SEG_W-1:0] seg_n
);
    // Active-low, bit order {g,f,e,d,c,b,a}.
    always_comb begin
        unique case (val)
            ST_D0: seg_n = 7'h40;
            ST_D1: seg_n = 7'h79;
            ST_D2: seg_n = 7'h24;
            ST_D3: seg_n = 7'h30;
            ST_D4: seg_n = 7'h19;
            ST_D5: seg_n = 7'h12;
            ST_D6: seg_n = 7'h02;
            ST_D7: seg_n = 7'h78;
            default: seg_n = '1;
        endcase
    end
endmodule

// File: rtl/seq6_jk_counter.sv
module seq6_jk_counter
    import seq6_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic [SEG_W-1:0] seg_n
);
    logic [CNT_W-1:0] j_in;
    logic [CNT_W-1:0] k_in;
    logic [CNT_W-1:0] q_st;
    cnt_state_e       cur_st;

    assign cur_st = cnt_state_e'(q_st);

    seq6_excite u_excite (
        .cur (cur_st),
        .en  (en),
        .j   (j_in),
        .k   (k_in)
    );

    seq6_jk_bank #(
        .W    (CNT_W),
        .INIT (ST_START)
    ) u_bank (
        .clk   (clk),
        .clr_n (rst_n),
        .j     (j_in),
        .k     (k_in),
        .q     (q_st)
    );

    seq6_seg_decode u_seg (
        .val   (cur_st),
        .seg_n (seg_n)
    );

    assign count = q_st;
endmodule

// File: rtl/seq6_jk_counter_chk.sv
module seq6_jk_counter_chk
    import seq6_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] count,
    input logic [SEG_W-1:0] seg_n
);
    function automatic logic [CNT_W-1:0] loop_next(input logic [CNT_W-1:0] v);
        case (v)
            3'd6: return 3'd5;
            3'd5: return 3'd2;
            3'd2: return 3'd4;
            3'd4: return 3'd1;
            3'd1: return 3'd0;
            default: return 3'd6;
        endcase
    endfunction

    function automatic logic [SEG_W-1:0] glyph(input logic [CNT_W-1:0] v);
        case (v)
            3'd0: return 7'h40;
            3'd1: return 7'h79;
            3'd2: return 7'h24;
            3'd3: return 7'h30;
            3'd4: return 7'h19;
            3'd5: return 7'h12;
            3'd6: return 7'h02;
            default: return 7'h78;
        endcase
    endfunction

    // R1: while clear is low, the state sits at the loop entry
    a_r1_clear_value: assert property (@(posedge clk) !rst_n |-> count == 3'd6);

    // R2: step along the loop
    a_r2_loop_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && en && count != 3'd3 && count != 3'd7
        |=> !rst_n || count == loop_next($past(count)));

    // R3: hold while disabled
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && !en |=> !rst_n || $stable(count));

    // R4: recovery from unused codes
    a_r4_recover: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && en && (count == 3'd3 || count == 3'd7) |=> !rst_n || count == 3'd6);

    // R5: bit 0 never stays high across an enabled edge
    a_r5_bit0_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n && en && count[0] |=> !rst_n || !count[0]);

    // R7: display pattern tracks the state
    a_r7_glyph: assert property (@(posedge clk) disable iff (!rst_n)
        seg_n == glyph(count));
endmodule

bind seq6_jk_counter seq6_jk_counter_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .count (count),
    .seg_n (seg_n)
);

// File: tb/seq6_jk_counter_test.sv
`timescale 1ns/1ps
module seq6_jk_counter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       en = 1'b0;
    logic [2:0] count;
    logic [6:0] seg_n;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    seq6_jk_counter uut (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .count (count),
        .seg_n (seg_n)
    );

    always #2.5 clk = ~clk;

    function automatic int exp_next(input int v);
        case (v)
            6: return 5;
            5: return 2;
            2: return 4;
            4: return 1;
            1: return 0;
            default: return 6;
        endcase
    endfunction

    function automatic int exp_seg(input int v);
        case (v)
            0: return 'h40;
            1: return 'h79;
            2: return 'h24;
            3: return 'h30;
            4: return 'h19;
            5: return 'h12;
            6: return 'h02;
            default: return 'h78;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // R1: asynchronous clear, before any clock edge and after release
    task automatic t_reset();
        #0.5 rst_n = 1'b0;
        #1.0;
        chk("R1 count async", int'(count), 6);
        chk("R7 seg at reset", int'(seg_n), exp_seg(6));
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1.0;
        chk("R1 count after release", int'(count), 6);
    endtask

    // R2, R5, R6, R7: two full laps
    task automatic t_loop();
        int v;
        v = int'(count);
        @(negedge clk) en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk);
            #1.0;
            v = exp_next(v);
            chk("R2 loop step", int'(count), v);
            chk("R7 seg follows", int'(seg_n), exp_seg(v));
            if (v == 0 || v == 2 || v == 4 || v == 6)
                chk("R5 bit0 low", int'(count[0]), v % 2);
            #3.0;
            chk("R6 stable in cycle", int'(count), v);
        end
    endtask

    // R3: hold with enable low
    task automatic t_hold();
        int v;
        @(negedge clk) en = 1'b0;
        v = int'(count);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk);
            #1.0;
            chk("R3 hold", int'(count), v);
        end
        @(negedge clk) en = 1'b1;
        @(posedge clk);
        #1.0;
        chk("R2 resume after hold", int'(count), exp_next(v));
    endtask

    // Place the state in an unused code while the clear holds, then leave it there.
    task automatic put_code(input logic [2:0] code, input logic en_val);
        @(negedge clk);
        rst_n = 1'b0;
        en = en_val;
        @(negedge clk);
        force uut.u_bank.q_r = code;
        #0.5 release uut.u_bank.q_r;
        #0.5 rst_n = 1'b1;
        #0.2;
        chk("R7 seg unused code", int'(seg_n), exp_seg(int'(code)));
    endtask

    // R3, R4: unused codes
    task automatic t_unused();
        put_code(3'd3, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            #1.0;
            chk("R3 hold on code 3", int'(count), 3);
        end
        @(negedge clk) en = 1'b1;
        @(posedge clk);
        #1.0;
        chk("R4 recover from 3", int'(count), 6);

        put_code(3'd7, 1'b1);
        chk("R4 code 7 present", int'(count), 7);
        @(posedge clk);
        #1.0;
        chk("R4 recover from 7", int'(count), 6);
        chk("R5 bit0 cleared from 7", int'(count[0]), 0);
        @(posedge clk);
        #1.0;
        chk("R2 rejoin loop", int'(count), 5);
    endtask

    // R1: clear in mid-cycle from a state deep in the loop
    task automatic t_mid_clear();
        @(negedge clk) en = 1'b1;
        while (count != 3'd4) begin
            @(posedge clk);
            #1.0;
        end
        #0.5 rst_n = 1'b0;
        #0.5;
        chk("R1 clear mid-cycle", int'(count), 6);
        @(posedge clk);
        #1.0;
        chk("R1 held through edge", int'(count), 6);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1.0;
        chk("R2 first step after clear", int'(count), 5);
    endtask

    initial begin
        t_reset();
        t_loop();
        t_hold();
        t_unused();
        t_mid_clear();
        finish_run();
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected done at %0t", $time);
        finish_run();
    end
endmodule